// File: doc/BRIEF.md
# Image sensor bring-up sequencer

This block is a host-side controller that takes an imaging front-end, one with its own timing generator, from power-on into master-mode operation. A start pulse, accepted only while the supplies-good input is high, launches a fixed ordered series of register writes. Each write is offered on a simple address/data/valid/ready request port, and the serial link that carries it is handled elsewhere. Between the soft reset and the normal-power writes, the block walks a user-supplied table of timing writes. It reads that table through an index output and an address/data input pair with one cycle of read latency.

Two configuration bits are captured at start. One adds a write that powers the crystal-drive clock output. The other adds a write that selects a double-rate input clock. The timing-core release write is held back until a settle time has elapsed since start. After the master-mode write, the block raises a driver-enable output. After the output-enable write, it drives the synchronisation output low for a guaranteed width and then high again, and it reports done. Settle and pulse widths are given in nanoseconds and converted to clock cycles with rounding up.

Top module: `sensor_bringup_seq`

## Requirements
- R1: After reset, and until a start is accepted, `wr_valid_o`, `drv_en_o` and `done_o` are 0 and `sync_o` is 1.
- R2: A start pulse while `pwr_good_i` is 0 is ignored: no write is offered and `done_o` keeps its value.
- R3: An accepted start produces these writes in this order (address/data, hex): 10/01, the user table, 00/04, EA/60, 16/01 (conditional), 30/01 (conditional), 15/01, 20/01, 11/01.
- R4: Once `wr_valid_o` is raised, it stays high with a stable address and data until `wr_ready_i` is sampled high. Each cycle with valid and ready both high transfers exactly one write.
- R5: The 16/01 write is issued only when `cfg_xtal_i` was 1 at start.
- R6: The 30/01 write is issued only when `cfg_dblclk_i` was 1 at start, and it precedes the 15/01 write.
- R7: The 15/01 write transfers no sooner than SETTLE cycles after the start edge, where SETTLE = ceil(SETTLE_NS x CLK_FREQ_HZ / 1e9).
- R8: `drv_en_o` is 0 from start until the 20/01 write has transferred, and it is 1 by the time the 11/01 write transfers.
- R9: `sync_o` stays 1 until the 11/01 write transfers. It then goes low for exactly SYNC cycles, where SYNC = ceil(SYNC_LOW_NS x CLK_FREQ_HZ / 1e9), and returns high.
- R10: `done_o` rises one cycle after `sync_o` returns high. It holds until the next accepted start, which clears it together with `drv_en_o`.
- R11: A start pulse while a sequence is in progress is ignored.
- R12: User writes use indices 0 to `usr_count_i`-1 in ascending order. The table entry for an index is sampled at the second clock edge after `usr_idx_o` takes that value. A count of 0 issues no user write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled each cycle |
| pwr_good_i | input | 1 | Supplies and master clock are up; gates start |
| cfg_xtal_i | input | 1 | Crystal-drive clock output is used |
| cfg_dblclk_i | input | 1 | Input clock runs at double rate |
| usr_count_i | input | UIDX_W | Number of user timing writes |
| usr_idx_o | output | UIDX_W | Index into the user timing table |
| usr_addr_i | input | ADDR_W | Register address of the indexed user write |
| usr_data_i | input | DATA_W | Data of the indexed user write |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Write request address |
| wr_data_o | output | DATA_W | Write request data |
| wr_ready_i | input | 1 | Write request accepted when high with valid |
| drv_en_o | output | 1 | Enable for the vertical driver outputs |
| sync_o | output | 1 | Synchronisation output to the front-end |
| done_o | output | 1 | Bring-up complete |

## Verification
A wrong step register shows up on the very next write offer, as an address or data that does not match the expected order, a skipped conditional write, or an extra write. A wrong settle or pulse counter only becomes visible much later, when the timing-core release transfers or when `sync_o` returns high. The bench therefore measures those two intervals in cycles instead of relying on the order alone. A driver-enable or done flag that moves out of place is caught in the first cycle it differs, because both are compared on every clock against a model driven only by the observed write transfers.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_SRST    = 4'd1,
    S_USER    = 4'd2,
    S_NPWR_A  = 4'd3,
    S_NPWR_B  = 4'd4,
    S_OSC     = 4'd5,
    S_CLKDIV  = 4'd6,
    S_CORE    = 4'd7,
    S_MASTER  = 4'd8,
    S_DRVEN   = 4'd9,
    S_OUTC    = 4'd10,
    S_SYNC    = 4'd11,
    S_DONE    = 4'd12
  } step_t;

  typedef enum logic [1:0] {
    SB_PREP  = 2'd0,
    SB_FETCH = 2'd1,
    SB_WAIT  = 2'd2
  } sub_t;

  localparam logic [7:0] REG_SOFT_RESET = 8'h10;
  localparam logic [7:0] REG_POWER      = 8'h00;
  localparam logic [7:0] REG_BIAS       = 8'hEA;
  localparam logic [7:0] REG_OSC_OUT    = 8'h16;
  localparam logic [7:0] REG_CLK_HALF   = 8'h30;
  localparam logic [7:0] REG_CORE_RUN   = 8'h15;
  localparam logic [7:0] REG_MASTER     = 8'h20;
  localparam logic [7:0] REG_OUT_ENABLE = 8'h11;

  localparam logic [7:0] VAL_ONE   = 8'h01;
  localparam logic [7:0] VAL_POWER = 8'h04;
  localparam logic [7:0] VAL_BIAS  = 8'h60;

  function automatic step_t step_after(step_t s);
    return step_t'(s + 4'd1);
  endfunction

endpackage

// File: rtl/bringup_delay.sv
module bringup_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load_i)     cnt <= val_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/bringup_step_rom.sv
module bringup_step_rom
  import bringup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  step_t             step_i,
  input  logic [ADDR_W-1:0] usr_addr_i,
  input  logic [DATA_W-1:0] usr_data_i,
  output logic              has_write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    has_write_o = 1'b1;
    addr_o      = '0;
    data_o      = '0;
    case (step_i)
      S_SRST:   begin addr_o = ADDR_W'(REG_SOFT_RESET); data_o = DATA_W'(VAL_ONE);   end
      S_USER:   begin addr_o = usr_addr_i;              data_o = usr_data_i;         end
      S_NPWR_A: begin addr_o = ADDR_W'(REG_POWER);      data_o = DATA_W'(VAL_POWER); end
      S_NPWR_B: begin addr_o = ADDR_W'(REG_BIAS);       data_o = DATA_W'(VAL_BIAS);  end
      S_OSC:    begin addr_o = ADDR_W'(REG_OSC_OUT);    data_o = DATA_W'(VAL_ONE);   end
      S_CLKDIV: begin addr_o = ADDR_W'(REG_CLK_HALF);   data_o = DATA_W'(VAL_ONE);   end
      S_CORE:   begin addr_o = ADDR_W'(REG_CORE_RUN);   data_o = DATA_W'(VAL_ONE);   end
      S_MASTER: begin addr_o = ADDR_W'(REG_MASTER);     data_o = DATA_W'(VAL_ONE);   end
      S_OUTC:   begin addr_o = ADDR_W'(REG_OUT_ENABLE); data_o = DATA_W'(VAL_ONE);   end
      default:  has_write_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bringup_wr_port.sv
module bringup_wr_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fire_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign fire_o = valid_o & ready_i;

  // R4: a pending request keeps its content until it is taken
  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/sensor_bringup_seq.sv
module sensor_bringup_seq
  import bringup_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned SETTLE_NS   = 500_000,
  parameter int unsigned SYNC_LOW_NS = 100,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter int          UIDX_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              pwr_good_i,
  input  logic              cfg_xtal_i,
  input  logic              cfg_dblclk_i,
  input  logic [UIDX_W-1:0] usr_count_i,
  output logic [UIDX_W-1:0] usr_idx_o,
  input  logic [ADDR_W-1:0] usr_addr_i,
  input  logic [DATA_W-1:0] usr_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              drv_en_o,
  output logic              sync_o,
  output logic              done_o
);
  localparam longint unsigned NS_PER_S   = 64'd1_000_000_000;
  localparam longint unsigned SETTLE_CYC =
    (longint'(SETTLE_NS) * longint'(CLK_FREQ_HZ) + NS_PER_S - 64'd1) / NS_PER_S;
  localparam longint unsigned SYNC_CYC_R =
    (longint'(SYNC_LOW_NS) * longint'(CLK_FREQ_HZ) + NS_PER_S - 64'd1) / NS_PER_S;
  localparam longint unsigned SYNC_CYC   = (SYNC_CYC_R < 64'd1) ? 64'd1 : SYNC_CYC_R;
  localparam int SET_W = $clog2(SETTLE_CYC + 64'd1);
  localparam int SYN_W = $clog2(SYNC_CYC + 64'd1);
  localparam int LOW_W = $clog2(SYNC_CYC + 64'd2);
  localparam logic [SET_W-1:0] SETTLE_LD = SET_W'(SETTLE_CYC);
  localparam logic [SYN_W-1:0] SYNC_LD   = SYN_W'(SYNC_CYC - 64'd1);

  step_t             step;
  sub_t              sub;
  logic [UIDX_W-1:0] uidx;
  logic [UIDX_W-1:0] ucount_q;
  logic              xtal_q, dbl_q;
  logic              start_ok, skip, port_load, fire, has_write;
  logic              settle_zero, sync_zero, sync_load;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;

  assign start_ok  = (step == S_IDLE || step == S_DONE) && start_i && pwr_good_i;
  assign skip      = (step == S_USER   && ucount_q == '0) ||
                     (step == S_OSC    && !xtal_q)        ||
                     (step == S_CLKDIV && !dbl_q);
  assign port_load = has_write &&
                     ((sub == SB_PREP && !skip && step != S_USER &&
                       (step != S_CORE || settle_zero)) ||
                      sub == SB_FETCH);
  assign sync_load = (step == S_SYNC) && (sub == SB_PREP);
  assign usr_idx_o = uidx;

  bringup_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .step_i(step), .usr_addr_i(usr_addr_i), .usr_data_i(usr_data_i),
    .has_write_o(has_write), .addr_o(rom_addr), .data_o(rom_data));

  bringup_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .load_i(port_load), .addr_i(rom_addr), .data_i(rom_data),
    .ready_i(wr_ready_i), .valid_o(wr_valid_o), .addr_o(wr_addr_o),
    .data_o(wr_data_o), .fire_o(fire));

  bringup_delay #(.W(SET_W)) u_settle (
    .clk(clk), .rst(rst), .load_i(start_ok), .val_i(SETTLE_LD), .zero_o(settle_zero));

  bringup_delay #(.W(SYN_W)) u_sync (
    .clk(clk), .rst(rst), .load_i(sync_load), .val_i(SYNC_LD), .zero_o(sync_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= S_IDLE;
      sub      <= SB_PREP;
      uidx     <= '0;
      ucount_q <= '0;
      xtal_q   <= 1'b0;
      dbl_q    <= 1'b0;
      drv_en_o <= 1'b0;
      sync_o   <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      case (step)
        S_IDLE, S_DONE: begin
          if (start_ok) begin
            step     <= S_SRST;
            sub      <= SB_PREP;
            uidx     <= '0;
            ucount_q <= usr_count_i;
            xtal_q   <= cfg_xtal_i;
            dbl_q    <= cfg_dblclk_i;
            drv_en_o <= 1'b0;
            done_o   <= 1'b0;
          end else if (step == S_DONE) begin
            done_o <= 1'b1;
          end
        end
        S_DRVEN: begin
          drv_en_o <= 1'b1;
          step     <= S_OUTC;
          sub      <= SB_PREP;
        end
        S_SYNC: begin
          if (sub == SB_PREP) begin
            sync_o <= 1'b0;
            sub    <= SB_WAIT;
          end else if (sync_zero) begin
            sync_o <= 1'b1;
            step   <= S_DONE;
            sub    <= SB_PREP;
          end
        end
        default: begin
          case (sub)
            SB_PREP: begin
              if (skip)                              step <= step_after(step);
              else if (step == S_USER)               sub  <= SB_FETCH;
              else if (step != S_CORE || settle_zero) sub <= SB_WAIT;
            end
            SB_FETCH: sub <= SB_WAIT;
            default: begin
              if (fire) begin
                sub <= SB_PREP;
                if (step == S_USER &&
                    ({1'b0, uidx} + 1'b1) < {1'b0, ucount_q})
                  uidx <= uidx + 1'b1;
                else
                  step <= step_after(step);
              end
            end
          endcase
        end
      endcase
    end
  end

  // Checker state, used only by the assertions below
  logic             master_seen;
  logic [LOW_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || start_ok) master_seen <= 1'b0;
    else if (fire && wr_addr_o == ADDR_W'(REG_MASTER)) master_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || sync_o)     low_run <= '0;
    else if (low_run != '1) low_run <= low_run + 1'b1;
  end

  // R1: nothing is requested while idle after reset
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (step == S_IDLE) |-> (!wr_valid_o && !drv_en_o && !done_o));

  // R7: core release only after the settle counter has run out
  assert_core_after_settle_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && wr_addr_o == ADDR_W'(REG_CORE_RUN)) |-> settle_zero);

  // R8: driver enable never precedes the master-mode write
  assert_drv_after_master_R8: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> master_seen);

  // R9: sync low phase lasts the full rounded-up width
  assert_sync_width_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> (longint'(low_run) >= SYNC_CYC));

  // R10: done is only reported with sync back high
  assert_done_sync_high_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> sync_o);
endmodule

// File: tb/sensor_bringup_seq_bench.sv
module sensor_bringup_seq_bench;
  localparam int CLK_HZ  = 100_000_000;
  localparam int SET_NS  = 20_000;
  localparam int SYN_NS  = 95;
  localparam int MHZ     = CLK_HZ / 1_000_000;
  localparam int EXP_SET = (SET_NS * MHZ + 999) / 1000;
  localparam int EXP_SYN = (SYN_NS * MHZ + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, pwr_good_i = 1'b0;
  logic       cfg_xtal_i = 1'b0, cfg_dblclk_i = 1'b0;
  logic [5:0] usr_count_i = '0, usr_idx_o;
  logic [7:0] usr_addr_i = '0, usr_data_i = '0;
  logic       wr_valid_o, wr_ready_i = 1'b0;
  logic [7:0] wr_addr_o, wr_data_o;
  logic       drv_en_o, sync_o, done_o;

  always #5 clk = ~clk;

  sensor_bringup_seq #(.CLK_FREQ_HZ(CLK_HZ), .SETTLE_NS(SET_NS), .SYNC_LOW_NS(SYN_NS))
  u_sensor_bringup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .pwr_good_i(pwr_good_i),
    .cfg_xtal_i(cfg_xtal_i), .cfg_dblclk_i(cfg_dblclk_i), .usr_count_i(usr_count_i),
    .usr_idx_o(usr_idx_o), .usr_addr_i(usr_addr_i), .usr_data_i(usr_data_i),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ready_i(wr_ready_i), .drv_en_o(drv_en_o), .sync_o(sync_o), .done_o(done_o));

  int checks = 0, failures = 0;
  int q_addr[$], q_data[$];
  int cyc = 0, start_cyc = 0, rise_cyc = 0, low_n = 0;
  bit run_active = 0, master_f = 0, outc_f = 0, sync_up = 0;
  bit prev_pend = 0, rdy_mode = 0;
  logic [7:0] prev_addr = '0, prev_data = '0;
  logic [5:0] idx_d = '0;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [7:0] tab_addr(int i); return 8'(8'h40 + i); endfunction
  function automatic logic [7:0] tab_data(int i); return 8'(i * 7 + 3); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(int a);
    if (a == 8'h16) return "R5 crystal write";
    if (a == 8'h30) return "R6 clock-rate write";
    if (a >= 8'h40 && a < 8'h80) return "R12 user write";
    return "R3 write order";
  endfunction

  // table with one cycle of read latency, and the ready pattern
  initial forever begin
    @(negedge clk);
    usr_addr_i = tab_addr(int'(idx_d));
    usr_data_i = tab_data(int'(idx_d));
    idx_d      = usr_idx_o;
    lf         = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    wr_ready_i = rdy_mode ? (lf[0] | lf[3]) : 1'b1;
  end

  // behavioural reference, compared every cycle
  initial forever begin
    @(negedge clk);
    #2;
    cyc++;
    if (!rst) begin
      if (prev_pend)
        chk(wr_valid_o && wr_addr_o == prev_addr && wr_data_o == prev_data,
            "R4 hold while not ready", {wr_valid_o, wr_addr_o}, {1'b1, prev_addr});
      if (wr_valid_o && wr_ready_i) begin
        if (q_addr.size() == 0) chk(0, "R3 unexpected write", wr_addr_o, 0);
        else begin
          chk(wr_addr_o == q_addr[0] && wr_data_o == q_data[0], tag_for(q_addr[0]),
              {wr_addr_o, wr_data_o}, {q_addr[0][7:0], q_data[0][7:0]});
          void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
        if (wr_addr_o == 8'h15) chk(cyc - start_cyc >= EXP_SET, "R7 settle", cyc - start_cyc, EXP_SET);
        if (wr_addr_o == 8'h20) master_f = 1;
        if (wr_addr_o == 8'h11) begin
          chk(drv_en_o == 1'b1, "R8 enable before output write", drv_en_o, 1);
          outc_f = 1;
        end
      end
      if (!master_f) chk(drv_en_o == 1'b0, "R8 enable early", drv_en_o, 0);
      if (!outc_f) chk(sync_o == 1'b1, "R9 sync idle high", sync_o, 1);
      else if (sync_o == 1'b0) low_n++;
      else if (low_n > 0 && !sync_up) begin
        chk(low_n == EXP_SYN, "R9 sync low width", low_n, EXP_SYN);
        sync_up = 1; rise_cyc = cyc; run_active = 0;
      end
      chk(done_o == (sync_up && cyc > rise_cyc), "R10 done", done_o, sync_up && cyc > rise_cyc);
      prev_pend = wr_valid_o && !wr_ready_i;
      prev_addr = wr_addr_o; prev_data = wr_data_o;
      if (start_i && pwr_good_i && !run_active) begin
        start_cyc = cyc; run_active = 1;
        master_f = 0; outc_f = 0; sync_up = 0; low_n = 0;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run_seq(input bit x, input bit d, input int uc, input bit rm, input bit poke);
    q_addr.push_back(8'h10); q_data.push_back(8'h01);
    for (int i = 0; i < uc; i++) begin q_addr.push_back(tab_addr(i)); q_data.push_back(tab_data(i)); end
    q_addr.push_back(8'h00); q_data.push_back(8'h04);
    q_addr.push_back(8'hEA); q_data.push_back(8'h60);
    if (x) begin q_addr.push_back(8'h16); q_data.push_back(8'h01); end
    if (d) begin q_addr.push_back(8'h30); q_data.push_back(8'h01); end
    q_addr.push_back(8'h15); q_data.push_back(8'h01);
    q_addr.push_back(8'h20); q_data.push_back(8'h01);
    q_addr.push_back(8'h11); q_data.push_back(8'h01);
    cfg_xtal_i = x; cfg_dblclk_i = d; usr_count_i = 6'(uc); rdy_mode = rm;
    pulse_start();
    if (poke) begin
      repeat (40) @(negedge clk);
      pulse_start(); // R11: must be ignored mid-sequence
    end
    begin
      int t = 0;
      while (!sync_up && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R3 sequence completes (watchdog)", t, 20000);
    end
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, "R3 all writes issued", q_addr.size(), 0);
    #2 chk(done_o == 1'b1, "R10 done held", done_o, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(wr_valid_o == 1'b0, "R1 valid after reset", wr_valid_o, 0);
    chk(drv_en_o == 1'b0, "R1 enable after reset", drv_en_o, 0);
    chk(sync_o == 1'b1, "R1 sync after reset", sync_o, 1);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    pulse_start(); // R2: supplies not good
    repeat (30) @(negedge clk);
    #2 chk(wr_valid_o == 1'b0 && done_o == 1'b0, "R2 start ignored", wr_valid_o, 0);
    pwr_good_i = 1'b1;
    run_seq(0, 0, 3, 0, 0);
    run_seq(1, 1, 0, 1, 1);
    pwr_good_i = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk);
    #2 chk(done_o == 1'b1 && wr_valid_o == 1'b0, "R2 start ignored after done", done_o, 1);
    pwr_good_i = 1'b1;
    run_seq(1, 0, 5, 1, 0);
    run_seq(0, 1, 1, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_900_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule